// File: doc/BRIEF.md
# Privilege-Gated Control Register File

This block is the control and status register file of a small security-minded system-on-chip. It follows the privilege level of the CPU and uses it to decide, register by register, whether a bus read returns the stored value and whether a bus write takes effect. The same privilege level also decides whether the enable of an external SPI master may reach that master.

There are three privilege states, held in one state register:
- `MODE_FW` (firmware, code 0) is entered on reset.
- Transition `FW_TO_APP` moves from firmware to `MODE_APP` (application, code 1). It happens on a valid instruction fetch whose address equals the application start address.
- Transition `APP_TO_SYS` moves from application to `MODE_SYS` (syscall, code 2) while the access-level input is high.
- Transition `SYS_TO_APP` moves from syscall back to application when that input drops.

No transition leads back to firmware; only reset does. The CPU talks to the block over a word-addressed bus: chip select, write enable, address, write data, and a registered read-data return.

Top module: `priv_csr_gate`

## Requirements
- R1: After a synchronous active-low reset, the state is `MODE_FW` (code 0). The read data, the two scrambling outputs, the identity words and the SPI enable output are all zero.
- R2: A cycle with `fetch_valid` high and `fetch_addr` equal to `APP_START` (default 0x4000_0000) moves `MODE_FW` to `MODE_APP` at the next edge. A fetch from any other address leaves the state unchanged. Once the state has left `MODE_FW`, it never returns there until reset.
- R3: In `MODE_APP`, a high `acc_hi` moves the state to `MODE_SYS` at the next edge. In `MODE_SYS`, a low `acc_hi` moves it back to `MODE_APP`. In `MODE_FW`, `acc_hi` has no effect.
- R4: The two device-identity words at addresses 0x00 and 0x01 read as parameters `UID_W0` and `UID_W1` in `MODE_FW` only. In the other two states they read as zero.
- R5: The eight configuration-identity words at addresses 0x08 to 0x0F accept writes only in `MODE_FW`. Writes in other states leave them unchanged. They read back their stored value in every state.
- R6: The address-scrambling key (0x10, low 15 bits) and the data-scrambling key (0x11, 32 bits) accept writes only in `MODE_FW` and drive `scr_addr_key` and `scr_data_key`. A bus read of either address always returns zero.
- R7: Bit 0 of the SPI control word at 0x18 is writable and readable in every state. `spi_en` equals that bit, except that in `MODE_APP` it is forced low.
- R8: `rdata` carries the result of a read one cycle after the request (chip select high, write enable low). It is zero for unmapped addresses, for blocked reads, and in every cycle that follows a non-read.
- R9: A write or read issued in the same cycle as a state change is judged by the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Bus request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| fetch_valid | input | 1 | CPU instruction fetch valid |
| fetch_addr | input | 32 | CPU instruction fetch address |
| acc_hi | input | 1 | Raised access level (syscall request) |
| spi_en | output | 1 | Gated SPI master enable |
| scr_addr_key | output | 15 | Address-scrambling key |
| scr_data_key | output | 32 | Data-scrambling key |
| mode | output | 2 | Current state: 0 firmware, 1 application, 2 syscall |

## Verification
Every register in the block is updated on the edge at which its request is sampled. The timing that follows from this is:
- Read data appears one cycle after the read request.
- A state change appears at the edge after the fetch or `acc_hi` change that causes it.
- `spi_en`, the scrambling keys and the identity words follow the write edge directly.

The bench drives inputs on falling edges. Each read pushes its expected word into a queue, and a monitor pops and compares on the falling edge after the edge that captured the read. Port-level checks of `mode`, `spi_en` and the keys sit on the falling edge that follows the causing edge, so every comparison falls exactly one edge after its stimulus.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic [1:0] {
        MODE_FW  = 2'd0,
        MODE_APP = 2'd1,
        MODE_SYS = 2'd2
    } mode_t;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_UID0    = 8'h00;
    localparam logic [ADDR_W-1:0] A_UID1    = 8'h01;
    localparam logic [ADDR_W-1:0] A_CFG_ID  = 8'h08;
    localparam int                CFG_WORDS = 8;
    localparam logic [ADDR_W-1:0] A_SCR_ADR = 8'h10;
    localparam logic [ADDR_W-1:0] A_SCR_DAT = 8'h11;
    localparam logic [ADDR_W-1:0] A_SPI_CTL = 8'h18;

    localparam int SCR_ADDR_W = 15;

endpackage

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
    import priv_pkg::*;
#(
    parameter logic [31:0] APP_START = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_addr,
    input  logic        acc_hi,
    output mode_t       mode,
    output logic        in_fw,
    output logic        in_app
);

    mode_t state_q, state_d;
    logic  app_fetch;

    assign app_fetch = fetch_valid && (fetch_addr == APP_START);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_FW;
        else        state_q <= state_d;
    end

    // transitions: FW_TO_APP, APP_TO_SYS, SYS_TO_APP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_FW:  if (app_fetch) state_d = MODE_APP;
            MODE_APP: if (acc_hi)    state_d = MODE_SYS;
            MODE_SYS: if (!acc_hi)   state_d = MODE_APP;
            default:                 state_d = MODE_FW;
        endcase
    end

    // outputs
    always_comb begin
        mode   = state_q;
        in_fw  = 1'b0;
        in_app = 1'b0;
        unique case (state_q)
            MODE_FW:  in_fw  = 1'b1;
            MODE_APP: in_app = 1'b1;
            MODE_SYS: ;
            default:  ;
        endcase
    end

    // R2: firmware is left only forward
    a_r2_no_return_fw: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_FW) |=> (state_q != MODE_FW));

    // R2: a fetch from elsewhere keeps firmware
    a_r2_wrong_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_FW && !(fetch_valid && fetch_addr == APP_START)) |=> (state_q == MODE_FW));

    // R3: dropping the access level leaves syscall
    a_r3_sys_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_SYS && !acc_hi) |=> (state_q == MODE_APP));

    // R3: raising it in application enters syscall
    a_r3_sys_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_APP && acc_hi) |=> (state_q == MODE_SYS));

endmodule

// File: rtl/priv_spi_gate.sv
module priv_spi_gate
    import priv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  en_req,
    output logic  spi_en
);

    always_comb begin
        unique case (mode)
            MODE_FW:  spi_en = en_req;
            MODE_SYS: spi_en = en_req;
            MODE_APP: spi_en = 1'b0;
            default:  spi_en = 1'b0;
        endcase
    end

    // R7: entering application mode silences the master at that edge
    a_r7_app_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == MODE_APP) |-> !spi_en);

endmodule

// File: rtl/priv_reg_bank.sv
module priv_reg_bank
    import priv_pkg::*;
#(
    parameter logic [DATA_W-1:0] UID_W0 = 32'hA5C3_0011,
    parameter logic [DATA_W-1:0] UID_W1 = 32'h5A3C_0022
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  in_fw,
    output logic [DATA_W-1:0]     rdata,
    output logic                  spi_req,
    output logic [SCR_ADDR_W-1:0] scr_addr_key,
    output logic [DATA_W-1:0]     scr_data_key
);

    localparam int IDX_W = $clog2(CFG_WORDS);

    logic                           wr, rd;
    logic                           hit_cfg;
    logic [IDX_W-1:0]               cfg_idx;
    logic [ADDR_W-1:0]              cfg_off;
    logic [CFG_WORDS-1:0][DATA_W-1:0] cfg_q;
    logic [SCR_ADDR_W-1:0]          scr_a_q;
    logic [DATA_W-1:0]              scr_d_q;
    logic                           spi_q;
    logic [DATA_W-1:0]              rd_d, rd_q;
    logic                           unused_wbits;

    assign wr      = cs && we;
    assign rd      = cs && !we;
    assign cfg_off = addr - A_CFG_ID;
    assign hit_cfg = (addr >= A_CFG_ID) && (cfg_off < ADDR_W'(CFG_WORDS));
    assign cfg_idx = cfg_off[IDX_W-1:0];
    assign unused_wbits = ^{cfg_off[ADDR_W-1:IDX_W]};

    // configuration identity: one word per generate slot
    for (genvar g = 0; g < CFG_WORDS; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (wr && in_fw && hit_cfg && cfg_idx == IDX_W'(g))
                cfg_q[g] <= wdata;
        end
    end

    // scrambling keys, firmware-only writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_a_q <= '0;
            scr_d_q <= '0;
        end else if (wr && in_fw) begin
            if (addr == A_SCR_ADR) scr_a_q <= wdata[SCR_ADDR_W-1:0];
            if (addr == A_SCR_DAT) scr_d_q <= wdata;
        end
    end

    // SPI control bit, open in every mode
    always_ff @(posedge clk) begin
        if (!rst_n)                       spi_q <= 1'b0;
        else if (wr && addr == A_SPI_CTL) spi_q <= wdata[0];
    end

    // read mux
    always_comb begin
        rd_d = '0;
        if (rd) begin
            if (addr == A_UID0 && in_fw)  rd_d = UID_W0;
            else if (addr == A_UID1 && in_fw) rd_d = UID_W1;
            else if (hit_cfg)             rd_d = cfg_q[cfg_idx];
            else if (addr == A_SPI_CTL)   rd_d = {{(DATA_W-1){1'b0}}, spi_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata        = rd_q;
    assign spi_req      = spi_q;
    assign scr_addr_key = scr_a_q;
    assign scr_data_key = scr_d_q;

    // R5: identity words are frozen outside firmware
    a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !in_fw |=> $stable(cfg_q));

    // R6: keys are frozen outside firmware
    a_r6_keys_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !in_fw |=> ($stable(scr_a_q) && $stable(scr_d_q)));

    // R6: keys never leak onto the bus
    a_r6_keys_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr == A_SCR_ADR || addr == A_SCR_DAT)) |=> (rdata == '0));

    // R4: device identity hidden outside firmware
    a_r4_uid_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !in_fw && (addr == A_UID0 || addr == A_UID1)) |=> (rdata == '0));

    // R8: no read, no data
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0));

endmodule

// File: rtl/priv_csr_gate.sv
module priv_csr_gate
    import priv_pkg::*;
#(
    parameter logic [31:0] APP_START = 32'h4000_0000,
    parameter logic [31:0] UID_W0    = 32'hA5C3_0011,
    parameter logic [31:0] UID_W1    = 32'h5A3C_0022
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_addr,
    input  logic        acc_hi,
    output logic        spi_en,
    output logic [14:0] scr_addr_key,
    output logic [31:0] scr_data_key,
    output logic [1:0]  mode
);

    mode_t cur_mode;
    logic  in_fw, in_app, spi_req;

    priv_mode_fsm #(.APP_START(APP_START)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .acc_hi(acc_hi),
        .mode(cur_mode), .in_fw(in_fw), .in_app(in_app)
    );

    priv_reg_bank #(.UID_W0(UID_W0), .UID_W1(UID_W1)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .in_fw(in_fw), .rdata(rdata), .spi_req(spi_req),
        .scr_addr_key(scr_addr_key), .scr_data_key(scr_data_key)
    );

    priv_spi_gate u_spi (
        .clk(clk), .rst_n(rst_n), .mode(cur_mode), .en_req(spi_req), .spi_en(spi_en)
    );

    assign mode = cur_mode;

    // R9: a firmware-mode write in the cycle of the application fetch still lands
    a_r9_old_mode_rules: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fw && cs && we && addr == A_SCR_DAT) |=> (scr_data_key == $past(wdata)));

    // R7: application state and an enabled master never coexist
    a_r7_no_app_spi: assert property (@(posedge clk) disable iff (!rst_n)
        in_app |-> !spi_en);

endmodule

// File: tb/priv_csr_gate_bench.sv
`timescale 1ns/1ps
module priv_csr_gate_bench;

    localparam logic [31:0] APP_START = 32'h4000_0000;
    localparam logic [31:0] UID0 = 32'hA5C3_0011;
    localparam logic [31:0] UID1 = 32'h5A3C_0022;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        acc_hi = 1'b0;
    logic        spi_en;
    logic [14:0] scr_addr_key;
    logic [31:0] scr_data_key;
    logic [1:0]  mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] cfg_model [8];

    always #2.5 clk = ~clk;

    priv_csr_gate #(.APP_START(APP_START), .UID_W0(UID0), .UID_W1(UID1)) u_priv_csr_gate (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .acc_hi(acc_hi), .spi_en(spi_en), .scr_addr_key(scr_addr_key),
        .scr_data_key(scr_data_key), .mode(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: a read captured at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_seen <= rst_n && cs && !we;

    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected read", rdata, 32'hxxxx_xxxx);
                end else begin
                    chk(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string req);
        cs = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic do_fetch(input logic [31:0] a);
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (cfg_model[i]) cfg_model[i] = '0;
    endtask

    task automatic try_locked_writes(input string st);
        for (int i = 0; i < 8; i++) bus_write(8'h08 + 8'(i), 32'hDEAD_0000 | 32'(i));
        for (int i = 0; i < 8; i++) bus_read(8'h08 + 8'(i), cfg_model[i], {"R5 cfg locked ", st});
        bus_write(8'h10, 32'h0000_7EEF);
        bus_write(8'h11, 32'hF00F_F00F);
        chk({"R6 addr key locked ", st}, {17'd0, scr_addr_key}, 32'h0000_1337);
        chk({"R6 data key locked ", st}, scr_data_key, 32'h4711_4711);
        bus_read(8'h10, 32'h0, {"R6 addr key reads zero ", st});
        bus_read(8'h11, 32'h0, {"R6 data key reads zero ", st});
        bus_read(8'h00, 32'h0, {"R4 uid0 hidden ", st});
        bus_read(8'h01, 32'h0, {"R4 uid1 hidden ", st});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 mode", {30'd0, mode}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        chk("R1 spi_en", {31'd0, spi_en}, 32'd0);
        chk("R1 addr key", {17'd0, scr_addr_key}, 32'd0);
        chk("R1 data key", scr_data_key, 32'd0);
        bus_read(8'h08, 32'h0, "R1 cfg word cleared");

        // firmware mode
        bus_read(8'h00, UID0, "R4 uid0 in fw");
        bus_read(8'h01, UID1, "R4 uid1 in fw");
        for (int i = 0; i < 8; i++) begin
            cfg_model[i] = 32'h0F1E_2D3C ^ (32'h1111_1111 * 32'(i));
            bus_write(8'h08 + 8'(i), cfg_model[i]);
        end
        for (int i = 0; i < 8; i++) bus_read(8'h08 + 8'(i), cfg_model[i], "R5 cfg write in fw");
        bus_write(8'h10, 32'hFFFF_1337);
        bus_write(8'h11, 32'h4711_4711);
        chk("R6 addr key set", {17'd0, scr_addr_key}, 32'h0000_1337);
        chk("R6 data key set", scr_data_key, 32'h4711_4711);
        bus_read(8'h10, 32'h0, "R6 addr key reads zero fw");
        bus_read(8'h11, 32'h0, "R6 data key reads zero fw");
        bus_read(8'h40, 32'h0, "R8 unmapped fw");
        bus_write(8'h18, 32'h1);
        chk("R7 spi on in fw", {31'd0, spi_en}, 32'd1);
        bus_read(8'h18, 32'h1, "R7 spi ctl readback fw");

        // R2 wrong fetch, R3 acc_hi ignored in firmware
        do_fetch(APP_START + 32'd4);
        chk("R2 wrong fetch keeps fw", {30'd0, mode}, 32'd0);
        acc_hi = 1'b1;
        @(negedge clk);
        chk("R3 acc_hi ignored in fw", {30'd0, mode}, 32'd0);
        acc_hi = 1'b0;

        // R9: write in same cycle as the application fetch uses firmware rules
        cs = 1'b1; we = 1'b1; addr = 8'h08; wdata = 32'hCAFE_0009;
        fetch_valid = 1'b1; fetch_addr = APP_START;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; fetch_valid = 1'b0;
        cfg_model[0] = 32'hCAFE_0009;
        chk("R2 fetch enters app", {30'd0, mode}, 32'd1);
        bus_read(8'h08, 32'hCAFE_0009, "R9 write with fetch edge lands");

        // application mode
        chk("R7 spi off in app", {31'd0, spi_en}, 32'd0);
        bus_read(8'h18, 32'h1, "R7 spi ctl still set in app");
        bus_write(8'h18, 32'h1);
        chk("R7 spi stays off after app write", {31'd0, spi_en}, 32'd0);
        try_locked_writes("app");
        bus_read(8'h40, 32'h0, "R8 unmapped app");
        do_fetch(APP_START);
        chk("R2 refetch stays app", {30'd0, mode}, 32'd1);

        // syscall
        acc_hi = 1'b1;
        @(negedge clk);
        chk("R3 enter sys", {30'd0, mode}, 32'd2);
        chk("R7 spi on in sys", {31'd0, spi_en}, 32'd1);
        try_locked_writes("sys");
        acc_hi = 1'b0;
        @(negedge clk);
        chk("R3 leave sys", {30'd0, mode}, 32'd1);
        chk("R7 spi off again in app", {31'd0, spi_en}, 32'd0);

        // R9: read issued on the edge that enters syscall is judged as application
        acc_hi = 1'b1;
        bus_read(8'h00, 32'h0, "R9 uid read on sys edge");
        chk("R2 no return to fw", {30'd0, mode}, 32'd2);
        acc_hi = 1'b0;
        @(negedge clk);

        // second reset returns to firmware
        do_reset();
        chk("R1 mode after second reset", {30'd0, mode}, 32'd0);
        chk("R1 key cleared", scr_data_key, 32'd0);
        bus_read(8'h00, UID0, "R4 uid visible after reset");
        bus_read(8'h09, 32'h0, "R1 cfg cleared after reset");

        repeat (3) @(negedge clk);
        chk("R8 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule